// File: doc/BRIEF.md
# Edge-Qualified Interrupt and Trap Capture

This block sits between five asynchronous event pins and a processor core. Four pins carry ordinary interrupt requests and the fifth carries a trap. Each pin is brought into the core clock domain by flops clocked on the falling edge of the clock. A low-to-high transition is accepted only when the pin was low for at least two samples and then stays high for at least two samples. An accepted transition posts a pending flag for its source. The flag stays set until the core acknowledges that source.

A posted source is offered to the core through a one-cycle service strobe with a source number. The strobe is not issued until the posting has aged a minimum number of cycles. Cycles in which the core reports a wait state do not count toward that age. When several sources are ready together, they are offered one per cycle in a fixed order. The trap pin is bidirectional. After reset it is an input. A debug control can turn it into a driven output, and while it drives, the block ignores the pin as a trap source.

Top module: `edge_irq_capture`

## Requirements
- R1: During and after reset, `pending` is all zero and `svc_req` is low; the trap pad starts as an input, so an edge driven onto it from outside posts a trap.
- R2: A pin that was low for two or more falling-edge samples and then high for two or more posts its pending flag. Pending bits [3:0] belong to `irq_pin[3:0]` and bit 4 belongs to the trap.
- R3: A high pulse that lasts a single cycle posts nothing.
- R4: A pin that drops low for only one cycle and rises again does not post a second time.
- R5: A pin held high for any length of time posts exactly once.
- R6: `svc_req` for a source is asserted exactly MIN_LAT (default 4) non-wait cycles after its pending flag is first seen set. Each cycle with `core_wait` high delays it by one cycle.
- R7: Each posting produces one single-cycle `svc_req` strobe. `svc_id` codes the source: 0 to 3 are the interrupts and 4 is the trap.
- R8: When several sources are ready together they are strobed one per cycle. The order is the trap first, then interrupt 0, 1, 2, 3.
- R9: A pending flag reads clear in the cycle after `ack` is high for its bit. A fresh edge on the same source in that same cycle keeps the flag set.
- R10: While `dbg_trap_oe` is high, the block drives `trap_pad` with `dbg_trap_level`, and toggling that level posts no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the pins are sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 4 | Interrupt request pins, active high |
| trap_pad | inout | 1 | Trap pin; an input after reset, driven while debug drive is on |
| dbg_trap_oe | input | 1 | Debug control that turns the trap pad into an output |
| dbg_trap_level | input | 1 | Level driven onto the trap pad when the debug drive is on |
| core_wait | input | 1 | Core wait state; freezes the latency count |
| ack | input | 5 | Per-source acknowledge, same bit order as `pending` |
| pending | output | 5 | Per-source pending flags |
| svc_req | output | 1 | One-cycle service strobe |
| svc_id | output | 3 | Source offered with the strobe (0-3 interrupts, 4 trap) |

## Verification
The hardest situation to reach is three sources becoming ready in the same cycle without any acknowledge. Only that case shows the strobe order and shows that a source already offered is not offered again. The bench raises the trap and two interrupts on the same clock with automatic acknowledge turned off. It then checks the order of the three strobes, and only afterwards clears the three flags with one acknowledge word. A second hard case is the latency count under wait states. The bench waits until a posting is visible and only then holds `core_wait`, so the added delay can be measured exactly.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NUM_IRQ  = 4;
  localparam int unsigned NUM_SRC  = NUM_IRQ + 1;
  localparam int unsigned TRAP_IDX = NUM_IRQ;
  localparam int unsigned ID_W     = $clog2(NUM_SRC);

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [ID_W-1:0]    src_id_t;

  // Fixed service order: trap, then interrupt 0 upward.
  function automatic src_id_t pick_winner(input src_vec_t ready);
    src_id_t win;
    logic    found;
    win   = '0;
    found = 1'b0;
    if (ready[TRAP_IDX]) begin
      win   = src_id_t'(TRAP_IDX);
      found = 1'b1;
    end
    for (int i = 0; i < int'(NUM_IRQ); i++) begin
      if (!found && ready[i]) begin
        win   = src_id_t'(i);
        found = 1'b1;
      end
    end
    return win;
  endfunction

  // Expected history pattern: newest HI samples high, older LO samples low.
  function automatic logic edge_ok(input logic [15:0] hist, input int hi, input int lo);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (i < hi && !hist[i]) ok = 1'b0;
      if (i >= hi && i < hi + lo && hist[i]) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/irqc_pin_qual.sv
module irqc_pin_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_HIGH    = 2,
  parameter int unsigned MIN_LOW     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic det
);
  import irqc_pkg::*;

  localparam int unsigned HIST_W = MIN_HIGH + MIN_LOW;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HIST_W-1:0]      hist_q;
  logic [15:0]            hist_ext;

  // Falling-edge synchronizer and level history (bit 0 newest).
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      hist_q <= {hist_q[HIST_W-2:0], sync_q[SYNC_STAGES-1]};
    end
  end

  assign hist_ext = 16'(hist_q);
  // Holds for exactly one clock period per qualified edge.
  assign det = edge_ok(hist_ext, int'(MIN_HIGH), int'(MIN_LOW));
endmodule

// File: rtl/irqc_src_track.sv
module irqc_src_track #(
  parameter int unsigned MIN_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det,
  input  logic ack,
  input  logic core_wait,
  input  logic grant,
  output logic pending,
  output logic ready
);
  localparam int unsigned AGE_W = $clog2(MIN_LAT + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(MIN_LAT);

  logic [AGE_W-1:0] age_q;
  logic             pend_q;
  logic             offered_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      offered_q <= 1'b0;
      age_q     <= '0;
    end else if (det) begin
      pend_q    <= 1'b1;
      offered_q <= 1'b0;
      age_q     <= '0;
    end else if (ack) begin
      pend_q    <= 1'b0;
      offered_q <= 1'b0;
      age_q     <= '0;
    end else if (pend_q) begin
      if (grant) offered_q <= 1'b1;
      if (!core_wait && age_q != AGE_MAX) age_q <= age_q + 1'b1;
    end
  end

  assign pending = pend_q;
  assign ready   = pend_q && !offered_q && (age_q == AGE_MAX);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter (
  input  irqc_pkg::src_vec_t ready,
  output logic               req,
  output irqc_pkg::src_id_t  id,
  output irqc_pkg::src_vec_t grant
);
  import irqc_pkg::*;

  always_comb begin
    req   = |ready;
    id    = pick_winner(ready);
    grant = '0;
    if (req) grant[id] = 1'b1;
  end
endmodule

// File: rtl/edge_irq_capture.sv
module edge_irq_capture #(
  parameter int unsigned MIN_LAT     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_HIGH    = 2,
  parameter int unsigned MIN_LOW     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] irq_pin,
  inout  wire        trap_pad,
  input  logic       dbg_trap_oe,
  input  logic       dbg_trap_level,
  input  logic       core_wait,
  input  logic [4:0] ack,
  output logic [4:0] pending,
  output logic       svc_req,
  output logic [2:0] svc_id
);
  import irqc_pkg::*;

  src_vec_t raw_vec;
  src_vec_t det_vec;
  src_vec_t ready_vec;
  src_vec_t grant_vec;
  src_id_t  win_id;
  logic     win_req;

  // Tri-state trap pad: input unless the debug drive is on.
  assign trap_pad = dbg_trap_oe ? dbg_trap_level : 1'bz;
  assign raw_vec  = {trap_pad & ~dbg_trap_oe, irq_pin};

  for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_src
    irqc_pin_qual #(
      .SYNC_STAGES(SYNC_STAGES),
      .MIN_HIGH   (MIN_HIGH),
      .MIN_LOW    (MIN_LOW)
    ) u_qual (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (raw_vec[g]),
      .det  (det_vec[g])
    );

    irqc_src_track #(
      .MIN_LAT(MIN_LAT)
    ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .det      (det_vec[g]),
      .ack      (ack[g]),
      .core_wait(core_wait),
      .grant    (grant_vec[g]),
      .pending  (pending[g]),
      .ready    (ready_vec[g])
    );
  end

  irqc_arbiter u_arb (
    .ready(ready_vec),
    .req  (win_req),
    .id   (win_id),
    .grant(grant_vec)
  );

  assign svc_req = win_req;
  assign svc_id  = 3'(win_id);
endmodule

// File: rtl/edge_irq_capture_chk.sv
module edge_irq_capture_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trap_pad,
  input logic       dbg_trap_oe,
  input logic       dbg_trap_level,
  input logic [4:0] ack,
  input logic [4:0] pending,
  input logic       svc_req,
  input logic [2:0] svc_id,
  input logic [4:0] det_vec,
  input logic [4:0] ready_vec
);
  logic [4:0] det_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) det_d <= '0;
    else        det_d <= det_vec;
  end

  // R5: a qualified edge never lasts two sampled cycles.
  assert_det_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (det_vec & det_d) == 5'b0);

  // R7: a strobe always names a posted source.
  assert_req_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> pending[svc_id]);

  // R7: the same source is not strobed in two consecutive cycles.
  assert_strobe_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |=> !(svc_req && svc_id == $past(svc_id)));

  // R6: a source just posted is not strobed in the next cycle.
  assert_no_early_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> !det_d[svc_id]);

  // R8: the trap is never passed over when it is ready.
  assert_trap_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req && svc_id != 3'd4) |-> !ready_vec[4]);

  // R9: acknowledge without a fresh edge clears the flag.
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & ~det_vec) != 5'b0) |=> ((pending & $past(ack & ~det_vec)) == 5'b0));

  // R10: the pad follows the debug level while driven.
  assert_pad_driven_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_trap_oe |-> (trap_pad == dbg_trap_level));
endmodule

bind edge_irq_capture edge_irq_capture_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .trap_pad      (trap_pad),
  .dbg_trap_oe   (dbg_trap_oe),
  .dbg_trap_level(dbg_trap_level),
  .ack           (ack),
  .pending       (pending),
  .svc_req       (svc_req),
  .svc_id        (svc_id),
  .det_vec       (det_vec),
  .ready_vec     (ready_vec)
);

// File: tb/edge_irq_capture_tb.sv
module edge_irq_capture_tb;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq_pin = '0;
  logic       tb_trap_en = 1'b1;
  logic       tb_trap_val = 1'b0;
  logic       dbg_trap_oe = 1'b0;
  logic       dbg_trap_level = 1'b0;
  logic       core_wait = 1'b0;
  logic [4:0] ack_manual = '0;
  logic [4:0] ack_auto = '0;
  logic [4:0] ack;
  logic [4:0] pending;
  logic       svc_req;
  logic [2:0] svc_id;
  wire        trap_pad;

  assign trap_pad = tb_trap_en ? tb_trap_val : 1'bz;
  assign ack = ack_manual | ack_auto;

  always #10 clk = ~clk;

  edge_irq_capture u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .trap_pad(trap_pad),
    .dbg_trap_oe(dbg_trap_oe), .dbg_trap_level(dbg_trap_level),
    .core_wait(core_wait), .ack(ack), .pending(pending),
    .svc_req(svc_req), .svc_id(svc_id)
  );

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  bit    auto_ack = 1'b1;
  string cur_tag = "R1";

  // Observation log
  int strobe_cnt[5];
  int last_strobe[5];
  int pend_rise[5];
  int order_q[$];
  bit prev_pend[5];
  bit obs_req;
  int obs_id;

  // Behavioural reference model
  int m_smp[5][6];
  bit m_det[5];
  bit m_pend[5];
  bit m_done[5];
  int m_age[5];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int model_winner();
    if (m_pend[4] && !m_done[4] && m_age[4] == LAT) return 4;
    for (int i = 0; i < 4; i++)
      if (m_pend[i] && !m_done[i] && m_age[i] == LAT) return i;
    return -1;
  endfunction

  always @(posedge clk) cyc++;

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin
        for (int k = 0; k < 6; k++) m_smp[i][k] = 0;
        m_det[i] = 1'b0;
      end
    end else begin
      for (int i = 0; i < 5; i++) begin
        int s;
        s = (i == 4) ? int'(trap_pad & ~dbg_trap_oe) : int'(irq_pin[i]);
        for (int k = 5; k > 0; k--) m_smp[i][k] = m_smp[i][k-1];
        m_smp[i][0] = s;
        m_det[i] = m_smp[i][2] == 1 && m_smp[i][3] == 1 &&
                   m_smp[i][4] == 0 && m_smp[i][5] == 0;
      end
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin
        m_pend[i] = 1'b0; m_done[i] = 1'b0; m_age[i] = 0;
      end
    end else begin
      int w;
      w = model_winner();
      for (int i = 0; i < 5; i++) begin
        if (m_det[i]) begin
          m_pend[i] = 1'b1; m_done[i] = 1'b0; m_age[i] = 0;
        end else if (ack[i]) begin
          m_pend[i] = 1'b0; m_done[i] = 1'b0; m_age[i] = 0;
        end else if (m_pend[i]) begin
          if (w == i) m_done[i] = 1'b1;
          if (!core_wait && m_age[i] < LAT) m_age[i]++;
        end
      end
    end
  end

  // Compare every clock, well away from the rising edge.
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      int w;
      w = model_winner();
      for (int i = 0; i < 5; i++)
        chk(pending[i] == m_pend[i], cur_tag, int'(pending[i]), int'(m_pend[i]));
      chk(svc_req == (w >= 0), cur_tag, int'(svc_req), int'(w >= 0));
      if (svc_req && w >= 0) chk(int'(svc_id) == w, cur_tag, int'(svc_id), w);
      for (int i = 0; i < 5; i++) begin
        if (pending[i] && !prev_pend[i]) pend_rise[i] = cyc;
        prev_pend[i] = pending[i];
      end
      if (svc_req) begin
        strobe_cnt[svc_id]++;
        last_strobe[svc_id] = cyc;
        order_q.push_back(int'(svc_id));
      end
      obs_req = svc_req;
      obs_id  = int'(svc_id);
    end else begin
      obs_req = 1'b0;
    end
  end

  always @(posedge clk) begin
    #1;
    ack_auto = '0;
    if (auto_ack && obs_req) ack_auto[obs_id] = 1'b1;
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int base;
    for (int i = 0; i < 5; i++) begin
      strobe_cnt[i] = 0; last_strobe[i] = 0; pend_rise[i] = 0; prev_pend[i] = 1'b0;
    end
    tick(3);
    chk(pending == 5'b0, "R1", int'(pending), 0);
    chk(svc_req == 1'b0, "R1", int'(svc_req), 0);
    rst_n = 1'b1;
    tick(8);
    chk(pending == 5'b0, "R1", int'(pending), 0);

    // R2, R6: plain edge on interrupt 1, latency without waits
    cur_tag = "R2";
    irq_pin[1] = 1'b1; tick(3); irq_pin[1] = 1'b0; tick(14);
    chk(strobe_cnt[1] == 1, "R2", strobe_cnt[1], 1);
    chk(last_strobe[1] - pend_rise[1] == LAT, "R6", last_strobe[1] - pend_rise[1], LAT);

    // R3: single-cycle pulse is filtered
    cur_tag = "R3";
    irq_pin[2] = 1'b1; tick(1); irq_pin[2] = 1'b0; tick(12);
    chk(strobe_cnt[2] == 0, "R3", strobe_cnt[2], 0);
    chk(pending[2] == 1'b0, "R3", int'(pending[2]), 0);

    // R5: held high gives one request
    cur_tag = "R5";
    irq_pin[3] = 1'b1; tick(30);
    chk(strobe_cnt[3] == 1, "R5", strobe_cnt[3], 1);
    irq_pin[3] = 1'b0; tick(6);

    // R4: one-cycle low gap does not re-post
    cur_tag = "R4";
    irq_pin[0] = 1'b1; tick(3); irq_pin[0] = 1'b0; tick(1);
    irq_pin[0] = 1'b1; tick(3); irq_pin[0] = 1'b0; tick(16);
    chk(strobe_cnt[0] == 1, "R4", strobe_cnt[0], 1);

    // R8, R1, R7: three sources ready together, no acknowledge
    cur_tag = "R8";
    auto_ack = 1'b0;
    order_q.delete();
    tb_trap_val = 1'b1; irq_pin[0] = 1'b1; irq_pin[2] = 1'b1; tick(3);
    tb_trap_val = 1'b0; irq_pin[0] = 1'b0; irq_pin[2] = 1'b0; tick(14);
    chk(order_q.size() == 3, "R7", order_q.size(), 3);
    if (order_q.size() == 3) begin
      chk(order_q[0] == 4, "R8", order_q[0], 4);
      chk(order_q[1] == 0, "R8", order_q[1], 0);
      chk(order_q[2] == 2, "R8", order_q[2], 2);
    end
    chk(pending[4] == 1'b1, "R1", int'(pending[4]), 1);

    // R9: acknowledge clears in the following cycle
    cur_tag = "R9";
    ack_manual = 5'b10101; tick(1); ack_manual = '0;
    chk((pending & 5'b10101) == 5'b0, "R9", int'(pending), 0);
    auto_ack = 1'b1;
    tick(4);

    // R6: wait states stretch the latency
    cur_tag = "R6";
    irq_pin[1] = 1'b1;
    base = strobe_cnt[1];
    while (!pending[1]) tick(1);
    core_wait = 1'b1; tick(3); core_wait = 1'b0;
    irq_pin[1] = 1'b0; tick(12);
    chk(strobe_cnt[1] == base + 1, "R6", strobe_cnt[1], base + 1);
    chk(last_strobe[1] - pend_rise[1] == LAT + 3, "R6", last_strobe[1] - pend_rise[1], LAT + 3);

    // R10: debug drive of the trap pad
    cur_tag = "R10";
    base = strobe_cnt[4];
    tb_trap_en = 1'b0; dbg_trap_oe = 1'b1; dbg_trap_level = 1'b1; tick(3);
    chk(trap_pad == 1'b1, "R10", int'(trap_pad), 1);
    dbg_trap_level = 1'b0; tick(3);
    chk(trap_pad == 1'b0, "R10", int'(trap_pad), 0);
    dbg_trap_level = 1'b1; tick(4); dbg_trap_level = 1'b0; tick(8);
    chk(pending[4] == 1'b0, "R10", int'(pending[4]), 0);
    chk(strobe_cnt[4] == base, "R10", strobe_cnt[4], base);
    dbg_trap_oe = 1'b0; tb_trap_val = 1'b0; tb_trap_en = 1'b1; tick(8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule